// File: doc/BRIEF.md
# Coherent Timestamp Counter

This block keeps a wide cycle counter that advances on every clock edge from reset onward, with no enable and no setup. Software cannot read the whole counter in one access, so it reads it as two narrower words. A snapshot request returns the low word. On the same clock edge it copies the matching high word into a separate holding register. Software reads the holding register afterwards, and that later read belongs to the same counter value as the low word, even when the low word was about to carry.

A requester pulses `snapReq` for one cycle. One cycle later `snapValid` pulses, and both `snapLow` and `hiHold` show the captured value. Both outputs are plain levels. They keep their value until the next request, so reading them has no side effects.

Top module: `tsc_snapshot`

## Requirements
- R1: While `rstN` is low at a clock edge, the counter loads the parameter `RESET_VALUE` (default zero), and `snapLow`, `hiHold` and `snapValid` go to zero.
- R2: At every clock edge with `rstN` high, the counter increases by exactly one. Two snapshots taken N cycles apart differ by exactly N.
- R3: When `snapReq` is high at a clock edge, `snapLow` shows bits [WORD_W-1:0] of the counter value present at that edge, from the next cycle onward.
- R4: The same edge loads `hiHold` with bits [CNT_W-1:WORD_W] of that same counter value. This holds when the low word is all ones and the high word increments on the following edge.
- R5: `hiHold` and `snapLow` change only on an edge where `snapReq` is high. They hold their value for any number of cycles without a request.
- R6: When `snapReq` stays high over consecutive edges, each edge overwrites `snapLow` and `hiHold` with the newest counter value.
- R7: `snapValid` is high in exactly the cycle after each edge at which `snapReq` was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; the counter advances on each rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| snapReq | input | 1 | Snapshot request, sampled on the rising edge |
| snapLow | output | WORD_W | Low word of the latest snapshot |
| hiHold | output | CNT_W-WORD_W | Read-only holding register with the high word of the latest snapshot |
| snapValid | output | 1 | One-cycle pulse that marks a fresh snapshot |

## Verification
The checker verifies on every cycle that the counter steps by one, that each snapshot pair equals the counter value at the request edge, and that both words and the valid pulse follow the request timing. Only the bench scenarios exercise the cases that need a particular history. These are a snapshot taken just before and just after the low-word carry, a burst of back-to-back requests, and a long idle stretch in which the held words must not move. The bench starts the counter close to a carry through `RESET_VALUE` so that the carry happens within a short run.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic advance;  // step the counter this edge
    logic capture;  // copy both counter words into the output registers
  } tscStrobe_t;
endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       snapReq,
  output tscStrobe_t strobes,
  output logic       snapValid
);
  always_comb begin
    strobes.advance = 1'b1;
    strobes.capture = snapReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) snapValid <= 1'b0;
    else       snapValid <= snapReq;
  end
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int unsigned     CNT_W       = 64,
  parameter int unsigned     WORD_W      = 32,
  parameter logic [CNT_W-1:0] RESET_VALUE = '0,
  localparam int unsigned    HI_W        = CNT_W - WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tscStrobe_t        strobes,
  output logic [CNT_W-1:0]  countVal,
  output logic [WORD_W-1:0] snapLow,
  output logic [HI_W-1:0]   hiHold
);
  // one full-width adder; both words come from the same register state
  always_ff @(posedge clk) begin
    if (!rstN)                countVal <= RESET_VALUE;
    else if (strobes.advance) countVal <= countVal + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapLow <= '0;
      hiHold  <= '0;
    end else if (strobes.capture) begin
      snapLow <= countVal[WORD_W-1:0];
      hiHold  <= countVal[CNT_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/tsc_snapshot.sv
module tsc_snapshot
  import tsc_pkg::*;
#(
  parameter int unsigned      CNT_W       = 64,
  parameter int unsigned      WORD_W      = 32,
  parameter logic [CNT_W-1:0] RESET_VALUE = '0,
  localparam int unsigned     HI_W        = CNT_W - WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snapReq,
  output logic [WORD_W-1:0] snapLow,
  output logic [HI_W-1:0]   hiHold,
  output logic              snapValid
);
  tscStrobe_t       strobes;
  logic [CNT_W-1:0] countVal;

  tsc_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .snapReq   (snapReq),
    .strobes   (strobes),
    .snapValid (snapValid)
  );

  tsc_datapath #(
    .CNT_W       (CNT_W),
    .WORD_W      (WORD_W),
    .RESET_VALUE (RESET_VALUE)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .countVal (countVal),
    .snapLow  (snapLow),
    .hiHold   (hiHold)
  );
endmodule

// File: rtl/tsc_snapshot_chk.sv
module tsc_snapshot_chk #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HI_W  = CNT_W - WORD_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              snapReq,
  input logic [CNT_W-1:0]  countVal,
  input logic [WORD_W-1:0] snapLow,
  input logic [HI_W-1:0]   hiHold,
  input logic              snapValid
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> countVal == $past(countVal) + CNT_W'(1)); // R2

  AST_LOW_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    snapReq |=> snapLow == $past(countVal[WORD_W-1:0])); // R3

  AST_PAIR_COHERENT: assert property (@(posedge clk) disable iff (!rstN)
    snapReq |=> {hiHold, snapLow} == $past(countVal)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !snapReq |=> $stable(hiHold) && $stable(snapLow)); // R5

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    snapReq |=> snapValid); // R7

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !snapReq |=> !snapValid); // R7
endmodule

bind tsc_snapshot tsc_snapshot_chk #(
  .CNT_W  (CNT_W),
  .WORD_W (WORD_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .snapReq   (snapReq),
  .countVal  (countVal),
  .snapLow   (snapLow),
  .hiHold    (hiHold),
  .snapValid (snapValid)
);

// File: tb/tsc_snapshot_test.sv
module tsc_snapshot_test;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HI_W   = CNT_W - WORD_W;
  // start 32 cycles below a low-word carry
  localparam logic [CNT_W-1:0] INIT = 64'h0000_0007_FFFF_FFE0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snapReq = 1'b0;
  logic [WORD_W-1:0] snapLow;
  logic [HI_W-1:0]   hiHold;
  logic              snapValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [CNT_W-1:0] expCnt;
  logic [CNT_W-1:0] expQ[$];
  logic [CNT_W-1:0] lastSnap = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  tsc_snapshot #(.CNT_W(CNT_W), .WORD_W(WORD_W), .RESET_VALUE(INIT)) uut (
    .clk(clk), .rstN(rstN), .snapReq(snapReq),
    .snapLow(snapLow), .hiHold(hiHold), .snapValid(snapValid)
  );

  task automatic check(input bit ok, input string tag, input logic [CNT_W-1:0] act,
                       input logic [CNT_W-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference counter from R1/R2; pushes the expected pair on each request edge
  always @(posedge clk) begin
    if (!rstN) expCnt <= INIT;
    else begin
      if (snapReq) expQ.push_back(expCnt);
      expCnt <= expCnt + CNT_W'(1);
    end
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (rstN && snapValid) begin
      if (expQ.size() == 0) check(1'b0, "R7 stray valid", 64'd1, 64'd0);
      else begin
        logic [CNT_W-1:0] e;
        e = expQ.pop_front();
        lastSnap = e;
        check(snapLow == e[WORD_W-1:0], "R3 low word", {32'd0, snapLow}, {32'd0, e[WORD_W-1:0]});
        check(hiHold == e[CNT_W-1:WORD_W], "R4 high word", {32'd0, hiHold}, {32'd0, e[CNT_W-1:WORD_W]});
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic snap(input int n);
    for (int i = 0; i < n; i++) begin
      snapReq = 1'b1;
      @(negedge clk);
    end
    snapReq = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset values at the ports
    check(snapLow == '0, "R1 snapLow reset", {32'd0, snapLow}, 64'd0);
    check(hiHold == '0, "R1 hiHold reset", {32'd0, hiHold}, 64'd0);
    check(snapValid == 1'b0, "R1 snapValid reset", {63'd0, snapValid}, 64'd0);
    rstN = 1'b1;
    // R1: first snapshot right after reset sees the reset value
    snap(1);
    idle(1);
    check(lastSnap == INIT, "R1 counter starts at reset value", lastSnap, INIT);
    // R2: single snapshots at different spacings
    idle(3);
    snap(1);
    idle(5);
    snap(1);
    idle(1);
    // R4/R6: back-to-back burst across the low-word carry
    idle(12);
    snap(10);
    idle(2);
    check(expCnt[CNT_W-1:WORD_W] == 32'h8, "R4 carry reached", {32'd0, expCnt[CNT_W-1:WORD_W]}, 64'h8);
    // R5: long idle; held words must not move
    idle(40);
    check(hiHold == lastSnap[CNT_W-1:WORD_W], "R5 hiHold held", {32'd0, hiHold}, {32'd0, lastSnap[CNT_W-1:WORD_W]});
    check(snapLow == lastSnap[WORD_W-1:0], "R5 snapLow held", {32'd0, snapLow}, {32'd0, lastSnap[WORD_W-1:0]});
    check(snapValid == 1'b0, "R7 no valid while idle", {63'd0, snapValid}, 64'd0);
    // R6: another burst, then alternating requests
    snap(3);
    idle(1);
    snap(1); idle(1); snap(1);
    idle(3);
    check(expQ.size() == 0, "R7 every request answered", 64'(expQ.size()), 64'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule